// File: doc/BRIEF.md
# Octal Low-Side Channel Fault Diagnostics

This block sits beside the eight power switches of a low-side driver array and turns per-channel analog flags into a gated drive enable and one diagnostic status bit per channel. Each channel takes three inputs:

- a commanded-on signal;
- a comparator flag that is high when the output voltage is above the diagnostic threshold;
- a protection flag. This flag is overtemperature on the two lamp-type channels (1 and 2) and overcurrent on channels 3 to 8.

A protection event latches an overload that keeps the channel switched off until its command is withdrawn.

Status bit `i` belongs to channel `i+1`. The status encoding depends on how a channel is controlled. A channel driven serially reports the comparator level directly. Channels 1 and 2 can instead be driven from their parallel inputs. In that mode an "on" channel reports the inverted comparator level, so that a 1 always means healthy.

Channels 1 and 2 also pass their status through a digital stability filter and a fault latch. The fault latch is cleared while chip select is low, so the latch holds a fault from the moment it appears until the next serial access. Channels 3 to 8 present their status combinationally.

Top module: `lsd_fault_diag`

## Requirements
- R1: Reset behaviour. While `rstN` is low, all overload latches are cleared. After reset, `driveEn` equals `cmdOn` with no protection flag set. The status bits of channels 1 and 2 read 1.
- R2: On channels 3 to 8, `overFlag` high while the channel is commanded on forces that channel's `driveEn` low in the same cycle.
- R3: A latched overload keeps `driveEn` low after `overFlag` drops, for as long as `cmdOn` stays high. One cycle of `cmdOn` low clears the latch, and the next assertion of `cmdOn` drives the channel again.
- R4: On channels 1 and 2, `overFlag` (overtemperature) high while commanded on sets the overload latch at the next clock edge. That channel's `driveEn` is low from then on, until R3's release.
- R5: Serial-mode encoding. For any channel not in parallel mode, the status bit equals `vAbove` (1 means above threshold), whether the channel is on or off.
- R6: Parallel-mode encoding. Channel 1 or 2 is in parallel mode while its `parInN` bit is 0. In that mode the status bit equals `vAbove` when the channel is off, and equals `~vAbove` when it is on.
- R7: While a channel's overload latch is set, the channel reports the on-and-above fault code. That code is 1 in serial mode and 0 in parallel mode.
- R8: The status bits of channels 3 to 8 follow their inputs in the same cycle, with no filter and no latch.
- R9: On channels 1 and 2, a change of the encoded status reaches the output only after it has held for FILT_CYC+1 consecutive clock edges. A change that lasts fewer cycles is discarded.
- R10: On channels 1 and 2, a filtered fault code is latched while `csN` is high and stays on the status bit after the fault goes away. The latch clears at the first clock edge with `csN` low, after which the status shows the live filtered value. A fault is off-and-below, on-and-above, or an overload.
- R11: A fault on channel 1 or 2 that appears and disappears entirely while `csN` is low leaves no trace once `csN` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Serial chip select, active low; clears the channel 1–2 fault latches |
| parInN | input | NUM_FILT | Parallel control inputs of channels 1–2, 0 selects parallel mode |
| cmdOn | input | NUM_CH | Commanded-on state per channel |
| vAbove | input | NUM_CH | Output voltage above diagnostic threshold, per channel |
| overFlag | input | NUM_CH | Overtemperature (channels 1–2) or overcurrent (channels 3–8) flag |
| driveEn | output | NUM_CH | Gated gate-drive enable per channel |
| status | output | NUM_CH | Diagnostic status bit per channel |

## Verification
Two functions can collide in the same cycle on channels 1 and 2.

- **Overload while the fault latch is loading.** An overtemperature event sets the overload latch while the filter is already carrying a fault code toward the fault latch. The bench holds that flag with the channel in parallel mode and checks three things: the drive goes low one edge later, the parallel overload code 0 appears after the filter window, and that code survives the overload's release until chip select drops.
- **Fault latch clear against a live fault.** A chip-select pulse clears the fault latch while a fault is still being filtered. The bench keeps chip select low for a whole fault lifetime and judges that no residue remains after it rises.

// File: rtl/lsd_diag_pkg.sv
package lsd_diag_pkg;

  // Strobes handed from the control half to the status datapath, per channel.
  typedef struct packed {
    logic ovlHold;   // overload latch of this channel is set
    logic parMode;   // channel is driven from its parallel input
    logic clrLatch;  // fault latch clear request (chip select low)
  } chan_strobe_t;

  // Encoded status bit for a channel given its mode and state.
  function automatic logic encodeStatus(input logic parMode, input logic on,
                                        input logic ovl, input logic above);
    if (parMode) return ovl ? 1'b0 : (on ? ~above : above);
    else         return ovl ? 1'b1 : above;
  endfunction

  // Channel is in one of the fault conditions.
  function automatic logic isFault(input logic on, input logic ovl, input logic above);
    return ovl | (on & above) | (~on & ~above);
  endfunction

endpackage

// File: rtl/lsd_chan_ctrl.sv
module lsd_chan_ctrl
  import lsd_diag_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned NUM_FILT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic [NUM_FILT-1:0] parInN,
  input  logic [NUM_CH-1:0]   cmdOn,
  input  logic [NUM_CH-1:0]   overFlag,
  output logic [NUM_CH-1:0]   driveEn,
  output chan_strobe_t [NUM_CH-1:0] strobes
);

  logic [NUM_CH-1:0] ovlQ;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // Overload latch: set by the protection flag while on, dropped with the command.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ovlQ[i] <= 1'b0;
      else       ovlQ[i] <= cmdOn[i] & (ovlQ[i] | overFlag[i]);
    end

    if (i < NUM_FILT) begin : g_thermal
      // Thermal shutdown acts through the latch only.
      assign driveEn[i] = cmdOn[i] & ~ovlQ[i];
      assign strobes[i] = '{ovlHold: ovlQ[i], parMode: ~parInN[i], clrLatch: ~csN};
    end else begin : g_current
      // Overcurrent cuts the drive in the same cycle.
      assign driveEn[i] = cmdOn[i] & ~ovlQ[i] & ~overFlag[i];
      assign strobes[i] = '{ovlHold: ovlQ[i], parMode: 1'b0, clrLatch: ~csN};
    end
  end

endmodule

// File: rtl/lsd_status_path.sv
module lsd_status_path
  import lsd_diag_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned NUM_FILT = 2,
  parameter int unsigned FILT_CYC = 2000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CH-1:0]         cmdOn,
  input  logic [NUM_CH-1:0]         vAbove,
  input  chan_strobe_t [NUM_CH-1:0] strobes,
  output logic [NUM_CH-1:0]         status
);

  localparam int unsigned CNT_W = (FILT_CYC > 2) ? $clog2(FILT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(FILT_CYC - 1);
  localparam logic [1:0] IDLE_CODE = 2'b01; // {fault, statusBit}: healthy, reads 1

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i < NUM_FILT) begin : g_filt
      logic [1:0]       sample, cand, flt;
      logic [CNT_W-1:0] cnt;
      logic             latSet, latCode;

      always_comb begin
        sample[0] = encodeStatus(strobes[i].parMode, cmdOn[i], strobes[i].ovlHold, vAbove[i]);
        sample[1] = isFault(cmdOn[i], strobes[i].ovlHold, vAbove[i]);
      end

      // Stability filter: a new value must hold FILT_CYC+1 edges to pass.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cand <= IDLE_CODE;
          flt  <= IDLE_CODE;
          cnt  <= '0;
        end else if (sample != cand) begin
          cand <= sample;
          cnt  <= '0;
        end else if (flt != cand) begin
          if (cnt == CNT_LIM) flt <= cand;
          else                cnt <= cnt + 1'b1;
        end
      end

      // Fault latch: cleared while selected, captures filtered faults otherwise.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          latSet  <= 1'b0;
          latCode <= 1'b1;
        end else if (strobes[i].clrLatch) begin
          latSet  <= 1'b0;
        end else if (flt[1] && !latSet) begin
          latSet  <= 1'b1;
          latCode <= flt[0];
        end
      end

      assign status[i] = latSet ? latCode : flt[0];
    end else begin : g_direct
      assign status[i] = encodeStatus(strobes[i].parMode, cmdOn[i], strobes[i].ovlHold, vAbove[i]);
    end
  end

endmodule

// File: rtl/lsd_fault_diag.sv
module lsd_fault_diag
  import lsd_diag_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned NUM_FILT = 2,
  parameter int unsigned FILT_CYC = 2000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic [NUM_FILT-1:0] parInN,
  input  logic [NUM_CH-1:0]   cmdOn,
  input  logic [NUM_CH-1:0]   vAbove,
  input  logic [NUM_CH-1:0]   overFlag,
  output logic [NUM_CH-1:0]   driveEn,
  output logic [NUM_CH-1:0]   status
);

  chan_strobe_t [NUM_CH-1:0] strobes;

  lsd_chan_ctrl #(.NUM_CH(NUM_CH), .NUM_FILT(NUM_FILT)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .parInN(parInN), .cmdOn(cmdOn),
    .overFlag(overFlag), .driveEn(driveEn), .strobes(strobes)
  );

  lsd_status_path #(.NUM_CH(NUM_CH), .NUM_FILT(NUM_FILT), .FILT_CYC(FILT_CYC)) u_path (
    .clk(clk), .rstN(rstN), .cmdOn(cmdOn), .vAbove(vAbove), .strobes(strobes),
    .status(status)
  );

endmodule

// File: rtl/lsd_fault_diag_chk.sv
module lsd_fault_diag_chk #(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned NUM_FILT = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                csN,
  input logic [NUM_CH-1:0]   cmdOn,
  input logic [NUM_CH-1:0]   vAbove,
  input logic [NUM_CH-1:0]   overFlag,
  input logic [NUM_CH-1:0]   driveEn,
  input logic [NUM_CH-1:0]   status
);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    // Once a commanded channel is held off, it stays off while commanded (R3).
    assert_hold_off_R3: assert property (@(posedge clk) disable iff (!rstN)
      (cmdOn[k] && $past(cmdOn[k]) && $past(!driveEn[k])) |-> !driveEn[k]);

    if (k >= NUM_FILT) begin : g_cur
      // Overcurrent cuts drive in the same cycle (R2).
      assert_ovc_cut_R2: assert property (@(posedge clk) disable iff (!rstN)
        overFlag[k] |-> !driveEn[k]);
      // Driving serial channel reports the comparator level (R5).
      assert_serial_code_R5: assert property (@(posedge clk) disable iff (!rstN)
        (cmdOn[k] && driveEn[k]) |-> (status[k] == vAbove[k]));
    end else begin : g_therm
      // Overtemperature while on shuts drive at the next edge (R4).
      assert_therm_off_R4: assert property (@(posedge clk) disable iff (!rstN)
        ($past(cmdOn[k] && overFlag[k]) && cmdOn[k]) |-> !driveEn[k]);
    end
  end

endmodule

bind lsd_fault_diag lsd_fault_diag_chk #(.NUM_CH(NUM_CH), .NUM_FILT(NUM_FILT)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .cmdOn(cmdOn), .vAbove(vAbove),
  .overFlag(overFlag), .driveEn(driveEn), .status(status)
);

// File: tb/test_lsd_fault_diag.sv
module test_lsd_fault_diag;

  localparam int FILT = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic [1:0] parInN = 2'b11;
  logic [7:0] cmdOn = '0, vAbove = '1, overFlag = '0;
  logic [7:0] driveEn, status;

  int  nChecks = 0, nFails = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  lsd_fault_diag #(.NUM_CH(8), .NUM_FILT(2), .FILT_CYC(FILT)) i_lsd_fault_diag (
    .clk(clk), .rstN(rstN), .csN(csN), .parInN(parInN), .cmdOn(cmdOn),
    .vAbove(vAbove), .overFlag(overFlag), .driveEn(driveEn), .status(status)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Let filters settle, then clear fault latches with a select pulse.
  task automatic settle();
    step(FILT + 4);
    csN = 1'b0; step(2);
    csN = 1'b1; step(1);
  endtask

  task automatic t_reset();
    rstN = 1'b0; step(3);
    rstN = 1'b1; step(2);
    check("R1 status after reset", status, 8'hFF);
    check("R1 drive idle", driveEn, 8'h00);
    cmdOn = 8'hFF; #1;
    check("R1 drive follows command", driveEn, 8'hFF);
  endtask

  task automatic t_serial();
    parInN = 2'b11; cmdOn = 8'hFF; vAbove = 8'h00; #1;
    check("R8 direct channels same cycle", {6'b0, status[7:2]}, 8'h00);
    step(FILT);
    check("R9 ch1-2 not yet passed", {6'b0, status[1:0]}, 8'h03);
    step(1);
    check("R5 serial on below reads 0", {6'b0, status[1:0]}, 8'h00);
    cmdOn = 8'h00; vAbove = 8'hFF; #1;
    check("R5 serial off above reads 1", status | 8'h03, 8'hFF);
    settle();
    check("R5 serial off above ch1-2", status, 8'hFF);
  endtask

  task automatic t_parallel();
    parInN = 2'b00; cmdOn = 8'h03; vAbove = 8'h00;
    settle();
    check("R6 parallel on below reads 1", {6'b0, status[1:0]}, 8'h03);
    vAbove = 8'h03;
    step(FILT);
    check("R9 parallel fault still filtered", {6'b0, status[1:0]}, 8'h03);
    step(2);
    check("R6 parallel on above reads 0", {6'b0, status[1:0]}, 8'h00);
    vAbove = 8'h00;
    step(FILT + 4);
    check("R10 fault code held while csN high", {6'b0, status[1:0]}, 8'h00);
    csN = 1'b0; step(1);
    check("R10 latch cleared at csN low", {6'b0, status[1:0]}, 8'h03);
    csN = 1'b1;
    cmdOn = 8'h00; vAbove = 8'h03;
    step(FILT + 4);
    check("R6 parallel off above reads 1", {6'b0, status[1:0]}, 8'h03);
  endtask

  task automatic t_overcurrent();
    parInN = 2'b11; cmdOn = 8'hFF; vAbove = 8'h00; overFlag = 8'h00;
    settle();
    overFlag[4] = 1'b1; #1;
    check("R2 same-cycle cut", driveEn, 8'hEF);
    step(1);
    overFlag[4] = 1'b0;
    step(2);
    check("R3 held off after flag drops", driveEn, 8'hEF);
    check("R7 serial overload code 1", {7'b0, status[4]}, 8'h01);
    cmdOn[4] = 1'b0; step(1);
    cmdOn[4] = 1'b1; #1;
    check("R3 released after command low", driveEn, 8'hFF);
    check("R5 released channel reads comparator", {7'b0, status[4]}, 8'h00);
  endtask

  task automatic t_overtemp();
    parInN = 2'b10; cmdOn = 8'h01; vAbove = 8'h00; overFlag = 8'h00;
    settle();
    check("R6 ch1 parallel healthy", {7'b0, status[0]}, 8'h01);
    overFlag[0] = 1'b1; #1;
    check("R4 no same-cycle cut", {7'b0, driveEn[0]}, 8'h01);
    step(1);
    check("R4 off after edge", {7'b0, driveEn[0]}, 8'h00);
    overFlag[0] = 1'b0;
    step(FILT + 3);
    check("R4 stays off", {7'b0, driveEn[0]}, 8'h00);
    check("R7 parallel overload code 0", {7'b0, status[0]}, 8'h00);
    cmdOn[0] = 1'b0; vAbove[0] = 1'b1;
    step(FILT + 4);
    check("R10 overload code retained", {7'b0, status[0]}, 8'h00);
    csN = 1'b0; step(1); csN = 1'b1;
    check("R10 cleared to live value", {7'b0, status[0]}, 8'h01);
  endtask

  task automatic t_glitch();
    parInN = 2'b11; cmdOn = 8'h00; vAbove = 8'hFF; overFlag = 8'h00;
    settle();
    vAbove[1] = 1'b0;
    step(FILT / 2);
    vAbove[1] = 1'b1;
    step(FILT + 4);
    check("R9 short open-load pulse rejected", {7'b0, status[1]}, 8'h01);
  endtask

  task automatic t_select_window();
    parInN = 2'b11; cmdOn = 8'h00; vAbove = 8'hFF;
    settle();
    csN = 1'b0;
    vAbove[1] = 1'b0;
    step(FILT + 4);
    check("R10 live fault visible while selected", {7'b0, status[1]}, 8'h00);
    vAbove[1] = 1'b1;
    step(FILT + 4);
    csN = 1'b1;
    step(2);
    check("R11 fault inside select window gone", {7'b0, status[1]}, 8'h01);
  endtask

  initial begin
    t_reset();
    t_serial();
    t_parallel();
    t_overcurrent();
    t_overtemp();
    t_glitch();
    t_select_window();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule